// File: doc/BRIEF.md
# Block-Cipher FIFO Front End

This block is the data-movement shell around a block-cipher engine. The bus side writes plaintext words into an eight-word input queue and reads result words from an eight-word output queue. Between the two queues a processing core takes exactly one cipher block per job. A block is two words for a 64-bit cipher and four words for a 128-bit cipher. The front end reports occupancy flags and raises level interrupt requests and DMA requests for each direction, so that software or a DMA engine can keep the core fed.

The real cipher is not part of this block. A stand-in core replaces it. The stand-in XORs every word of the block with a key word and spends a fixed four cycles on each block, so the results can be predicted. The point of the block is its handshaking. A job starts only when a whole block is waiting at the input and a whole block of room is free at the output. A drain sequence ends with all status flags quiet at the same time. Context switches rely on that drain sequence.

Top module: `bcf_frontend`

## Requirements
- R1: The block size is 2 words when `cfg_blk4_i`=0 and 4 words when it is 1. The core removes words from the input queue only as one whole block, and it adds them to the output queue only as one whole block. A partial block stays in the input queue and produces no output.
- R2: The input queue holds 8 words. A write while it holds 8 words is dropped and leaves the queue contents unchanged.
- R3: `ifem_o` is 1 exactly when the input queue is empty. `ifnf_o` is 1 exactly when the input queue holds fewer than 8 words. `ofne_o` is 1 exactly when the output queue holds at least one word. `busy_o` is 1 exactly while the core holds a block.
- R4: A job starts only when all three of these hold: `cfg_enable_i` is 1, the input queue holds at least one block, and the output queue has room for one block. While any of these is missing, the core stays idle with `busy_o` low.
- R5: Each job keeps `busy_o` high for exactly 4 cycles. Output word i equals input word i XOR `cfg_key_i`, and words leave in the order they were written.
- R6: `in_irq_o` equals `ifnf_o` AND `in_irq_mask_i`. `out_irq_o` equals `ofne_o` AND `out_irq_mask_i`.
- R7: `in_dma_req_o` is 1 when `in_dma_en_i` is 1 and the input queue has room for a whole block. `out_dma_req_o` is 1 when `out_dma_en_i` is 1 and the output queue holds at least a whole block.
- R8: While the output queue is empty, `rd_data_o` reads zero, and a read request does not change the state of the block.
- R9: Once every written word has been read, `busy_o`=0, `ifem_o`=1 and `ofne_o`=0 hold together. Clearing `cfg_enable_i` stops any new job from starting, and data already waiting in the input queue stays there.
- R10: Clearing `in_dma_en_i` removes the input DMA request. The output DMA request keeps following the output queue, so the queues can drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_enable_i | input | 1 | Global enable for starting jobs |
| cfg_blk4_i | input | 1 | 1 selects 4-word blocks, 0 selects 2-word blocks |
| cfg_key_i | input | 32 | Key word for the stand-in transform |
| in_irq_mask_i | input | 1 | Input interrupt mask |
| out_irq_mask_i | input | 1 | Output interrupt mask |
| in_dma_en_i | input | 1 | Input DMA request enable |
| out_dma_en_i | input | 1 | Output DMA request enable |
| wr_valid_i | input | 1 | Write one word into the input queue |
| wr_data_i | input | 32 | Word to write |
| rd_req_i | input | 1 | Pop one word from the output queue |
| rd_data_o | output | 32 | Head of the output queue, zero when empty |
| ifem_o | output | 1 | Input queue empty |
| ifnf_o | output | 1 | Input queue not full |
| ofne_o | output | 1 | Output queue not empty |
| busy_o | output | 1 | Core is processing a block |
| in_irq_o | output | 1 | Input interrupt request |
| out_irq_o | output | 1 | Output interrupt request |
| in_dma_req_o | output | 1 | Input DMA request |
| out_dma_req_o | output | 1 | Output DMA request |

## Verification
The bench feeds a partial four-word block. A design that started on a partial block would show output data too early. It overfills the input queue with the core disabled. A design that accepted the ninth word would return an extra word at the end of the drain. It fills the output queue and then supplies more input. A design that ignored output room would overwrite unread results, or it would raise `busy_o` while stalled. Random write and read bursts in both block sizes compare every flag, interrupt and DMA request against a bench model of queue occupancy. The bench also counts the cycles of each job and checks the drained end state after the enable has been cleared.

// File: rtl/bcf_pkg.sv
package bcf_pkg;
    localparam int WORD_W    = 32;
    localparam int IN_DEPTH  = 8;
    localparam int OUT_DEPTH = 8;
    localparam int MAX_BLK   = 4;
    localparam int SMALL_BLK = 2;
    localparam int CORE_LAT  = 4;
endpackage

// File: rtl/bcf_fifo.sv
// Circular word queue; multi-word push and pop in a single cycle.
module bcf_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    parameter int PUSHN = 1,
    parameter int POPN  = 4,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int PUSHW = $clog2(PUSHN + 1),
    localparam int POPW  = $clog2(POPN + 1)
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [PUSHW-1:0]           push_n_i,
    input  logic [PUSHN-1:0][W-1:0]    push_data_i,
    input  logic [POPW-1:0]            pop_n_i,
    output logic [POPN-1:0][W-1:0]     peek_o,
    output logic [CW-1:0]              count_o
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wptr;
        logic [PW-1:0]           rptr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < PUSHN; i++) begin
            if (i < int'(push_n_i)) begin
                st_d.mem[st_q.wptr + PW'(i)] = push_data_i[i];
            end
        end
        st_d.wptr = st_q.wptr + PW'(push_n_i);
        st_d.rptr = st_q.rptr + PW'(pop_n_i);
        st_d.cnt  = st_q.cnt + CW'(push_n_i) - CW'(pop_n_i);
    end

    always_comb begin
        for (int i = 0; i < POPN; i++) begin
            peek_o[i] = st_q.mem[st_q.rptr + PW'(i)];
        end
    end

    assign count_o = st_q.cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(st_q.cnt) + int'(push_n_i) - int'(pop_n_i)) <= DEPTH);

    assert_no_underflow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(pop_n_i) <= int'(st_q.cnt));
endmodule

// File: rtl/bcf_core.sv
// Stand-in cipher: captures one block, XORs each word with the key,
// releases it after a fixed number of busy cycles.
module bcf_core #(
    parameter int W    = 32,
    parameter int MAXN = 4,
    parameter int LAT  = 4,
    localparam int NW  = $clog2(MAXN + 1),
    localparam int LW  = $clog2(LAT + 1)
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     start_i,
    input  logic [NW-1:0]            size_i,
    input  logic [W-1:0]             key_i,
    input  logic [MAXN-1:0][W-1:0]   block_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [NW-1:0]            size_o,
    output logic [MAXN-1:0][W-1:0]   block_o
);
    typedef struct packed {
        logic                   busy;
        logic [LW-1:0]          cnt;
        logic [NW-1:0]          size;
        logic [MAXN-1:0][W-1:0] data;
    } core_st_t;

    core_st_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (start_i && !c_q.busy) begin
            c_d.busy = 1'b1;
            c_d.cnt  = LW'(LAT - 1);
            c_d.size = size_i;
            for (int i = 0; i < MAXN; i++) begin
                c_d.data[i] = block_i[i] ^ key_i;
            end
        end else if (c_q.busy) begin
            if (c_q.cnt == '0) c_d.busy = 1'b0;
            else               c_d.cnt  = c_q.cnt - 1'b1;
        end
    end

    assign busy_o  = c_q.busy;
    assign done_o  = c_q.busy && (c_q.cnt == '0);
    assign size_o  = c_q.size;
    assign block_o = c_q.data;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    // Independent run-length counter for the busy window.
    logic [LW:0] run_d, run_q;
    always_comb run_d = busy_o ? run_q + 1'b1 : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) run_q <= '0;
        else         run_q <= run_d;
    end

    assert_busy_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (int'(run_q) < LAT));

    assert_done_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (int'(run_q) == LAT - 1));
endmodule

// File: rtl/bcf_frontend.sv
module bcf_frontend
    import bcf_pkg::*;
#(
    parameter int W        = WORD_W,
    parameter int IN_D     = IN_DEPTH,
    parameter int OUT_D    = OUT_DEPTH,
    parameter int BLK_BIG  = MAX_BLK,
    parameter int BLK_SML  = SMALL_BLK,
    parameter int LAT      = CORE_LAT
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         cfg_enable_i,
    input  logic         cfg_blk4_i,
    input  logic [W-1:0] cfg_key_i,
    input  logic         in_irq_mask_i,
    input  logic         out_irq_mask_i,
    input  logic         in_dma_en_i,
    input  logic         out_dma_en_i,
    input  logic         wr_valid_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         rd_req_i,
    output logic [W-1:0] rd_data_o,
    output logic         ifem_o,
    output logic         ifnf_o,
    output logic         ofne_o,
    output logic         busy_o,
    output logic         in_irq_o,
    output logic         out_irq_o,
    output logic         in_dma_req_o,
    output logic         out_dma_req_o
);
    localparam int NW     = $clog2(BLK_BIG + 1);
    localparam int CW_IN  = $clog2(IN_D + 1);
    localparam int CW_OUT = $clog2(OUT_D + 1);

    logic [NW-1:0]                blk_size;
    logic [CW_IN-1:0]             in_cnt;
    logic [CW_OUT-1:0]            out_cnt;
    logic [BLK_BIG-1:0][W-1:0]    in_peek;
    logic [0:0][W-1:0]            out_peek;
    logic                         wr_accept;
    logic                         start;
    logic                         rd_pop;
    logic [NW-1:0]                pop_in;
    logic [NW-1:0]                push_out;
    logic                         core_busy;
    logic                         core_done;
    logic [NW-1:0]                core_size;
    logic [BLK_BIG-1:0][W-1:0]    core_block;

    always_comb begin
        blk_size  = cfg_blk4_i ? NW'(BLK_BIG) : NW'(BLK_SML);
        wr_accept = wr_valid_i && (int'(in_cnt) < IN_D);
        start     = cfg_enable_i && !core_busy
                    && (int'(in_cnt) >= int'(blk_size))
                    && ((OUT_D - int'(out_cnt)) >= int'(blk_size));
        pop_in    = start ? blk_size : '0;
        push_out  = core_done ? core_size : '0;
        rd_pop    = rd_req_i && (out_cnt != '0);
    end

    bcf_fifo #(.W(W), .DEPTH(IN_D), .PUSHN(1), .POPN(BLK_BIG)) i_in_fifo (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_n_i    (wr_accept),
        .push_data_i (wr_data_i),
        .pop_n_i     (pop_in),
        .peek_o      (in_peek),
        .count_o     (in_cnt)
    );

    bcf_core #(.W(W), .MAXN(BLK_BIG), .LAT(LAT)) i_core (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start),
        .size_i  (blk_size),
        .key_i   (cfg_key_i),
        .block_i (in_peek),
        .busy_o  (core_busy),
        .done_o  (core_done),
        .size_o  (core_size),
        .block_o (core_block)
    );

    bcf_fifo #(.W(W), .DEPTH(OUT_D), .PUSHN(BLK_BIG), .POPN(1)) i_out_fifo (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_n_i    (push_out),
        .push_data_i (core_block),
        .pop_n_i     (rd_pop),
        .peek_o      (out_peek),
        .count_o     (out_cnt)
    );

    always_comb begin
        rd_data_o     = (out_cnt != '0) ? out_peek[0] : '0;
        ifem_o        = (in_cnt == '0);
        ifnf_o        = (int'(in_cnt) < IN_D);
        ofne_o        = (out_cnt != '0);
        busy_o        = core_busy;
        in_irq_o      = ifnf_o && in_irq_mask_i;
        out_irq_o     = ofne_o && out_irq_mask_i;
        in_dma_req_o  = in_dma_en_i && ((IN_D - int'(in_cnt)) >= int'(blk_size));
        out_dma_req_o = out_dma_en_i && (int'(out_cnt) >= int'(blk_size));
    end

    assert_in_dma_room_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_dma_req_o |-> ifnf_o);

    assert_out_dma_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_dma_req_o |-> ofne_o);

    assert_empty_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_req_i && !ofne_o && !core_done) |=> !ofne_o);

    assert_hold_disabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_enable_i && !busy_o) |=> !busy_o);

    assert_whole_block_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> (int'(in_cnt) == int'($past(in_cnt)) - int'($past(blk_size))
                                          + ($past(wr_accept) ? 1 : 0)));

    assert_out_room_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> (int'($past(out_cnt)) + int'($past(blk_size)) <= OUT_D));
endmodule

// File: tb/test_bcf_frontend.sv
`timescale 1ns/1ps
module test_bcf_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, blk4 = 1'b0;
    logic [31:0] key = '0;
    logic        im = 1'b0, om = 1'b0, di = 1'b0, dout = 1'b0;
    logic        wr_valid = 1'b0, rd_req = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ifem, ifnf, ofne, busy, in_irq, out_irq, in_dma, out_dma;

    int n_checks = 0, n_fail = 0;
    int in_m = 0, out_m = 0;
    bit finished = 0;
    logic [31:0] expq[$];

    always #2.5 clk = ~clk;

    bcf_frontend i_bcf_frontend (
        .clk_i(clk), .rst_ni(rst_n), .cfg_enable_i(en), .cfg_blk4_i(blk4),
        .cfg_key_i(key), .in_irq_mask_i(im), .out_irq_mask_i(om),
        .in_dma_en_i(di), .out_dma_en_i(dout), .wr_valid_i(wr_valid),
        .wr_data_i(wr_data), .rd_req_i(rd_req), .rd_data_o(rd_data),
        .ifem_o(ifem), .ifnf_o(ifnf), .ofne_o(ofne), .busy_o(busy),
        .in_irq_o(in_irq), .out_irq_o(out_irq), .in_dma_req_o(in_dma),
        .out_dma_req_o(out_dma));

    function automatic int blk();
        return blk4 ? 4 : 2;
    endfunction

    function automatic logic [31:0] xform(input logic [31:0] d, input logic [31:0] k);
        return d ^ k;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_settle();
        while (en && in_m >= blk() && (8 - out_m) >= blk()) begin
            in_m  -= blk();
            out_m += blk();
        end
    endtask

    task automatic settle();
        repeat (30) @(negedge clk);
        model_settle();
    endtask

    task automatic wr(input logic [31:0] d);
        bit take = (in_m < 8);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
        if (take) begin
            in_m++;
            expq.push_back(xform(d, key));
        end
    endtask

    task automatic rd(input string req);
        logic [31:0] got = rd_data;
        logic [31:0] exp = '0;
        if (out_m > 0) begin
            exp = expq.pop_front();
            out_m--;
        end
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk(req, got, exp);
    endtask

    task automatic check_flags();
        chk("R3 ifem", ifem, in_m == 0);
        chk("R3 ifnf", ifnf, in_m < 8);
        chk("R3 ofne", ofne, out_m > 0);
        chk("R3 busy idle", busy, 1'b0);
        chk("R6 in_irq", in_irq, im && (in_m < 8));
        chk("R6 out_irq", out_irq, om && (out_m > 0));
        chk("R7 in_dma", in_dma, di && ((8 - in_m) >= blk()));
        chk("R7 out_dma", out_dma, dout && (out_m >= blk()));
    endtask

    task automatic drain();
        while (in_m % blk() != 0) wr($urandom);
        settle();
        while (out_m > 0 || in_m > 0) begin
            while (out_m > 0) rd("R5 drain data");
            settle();
        end
    endtask

    initial begin
        #750000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int nb;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state, R3
        chk("R3 reset ifem", ifem, 1'b1);
        chk("R3 reset ifnf", ifnf, 1'b1);
        chk("R3 reset ofne", ofne, 1'b0);
        chk("R3 reset busy", busy, 1'b0);
        chk("R8 reset rd_data", rd_data, 32'h0);

        // R1: partial 4-word block waits
        en = 1'b1; blk4 = 1'b1; key = 32'hA5A5_0F0F;
        im = 1'b1; om = 1'b1; di = 1'b1; dout = 1'b1;
        wr(32'h1111_0001); wr(32'h1111_0002); wr(32'h1111_0003);
        settle();
        chk("R1 partial no output", ofne, 1'b0);
        chk("R1 partial kept", ifem, 1'b0);
        chk("R1 partial idle", busy, 1'b0);
        wr(32'h1111_0004);
        settle();
        check_flags();
        repeat (4) rd("R5 block4 data");
        settle();
        check_flags();

        // R5: busy window length for a 2-word block
        blk4 = 1'b0;
        wr(32'h2222_0001); wr(32'h2222_0002);
        begin
            int bc = 0;
            repeat (14) begin
                @(negedge clk);
                if (busy) bc++;
            end
            chk("R5 busy cycles", bc, 4);
        end
        model_settle();
        repeat (2) rd("R5 block2 data");

        // R2: overflow with processing disabled; R9 enable hold
        en = 1'b0;
        for (int k = 0; k < 9; k++) wr(32'h3333_0000 + k);
        settle();
        chk("R2 full ifnf", ifnf, 1'b0);
        chk("R9 disabled idle", busy, 1'b0);
        chk("R9 disabled keeps data", ofne, 1'b0);
        check_flags();
        en = 1'b1;
        settle();
        check_flags();
        // R4: output full stalls the core
        for (int k = 0; k < 8; k++) wr(32'h4444_0000 + k);
        settle();
        chk("R4 stall busy", busy, 1'b0);
        chk("R4 stall input kept", ifnf, 1'b0);
        check_flags();
        repeat (2) rd("R4 data after stall");
        settle();
        check_flags();
        // R10: input DMA off while output drains
        di = 1'b0;
        while (out_m > 0) rd("R2 data order");
        settle();
        chk("R10 in_dma off", in_dma, 1'b0);
        chk("R10 out_dma on", out_dma, out_m >= blk());
        check_flags();
        drain();
        // R8: read when empty
        rd("R8 empty read zero");
        chk("R8 empty read no effect", ofne, 1'b0);
        di = 1'b1;

        // random phase
        for (int it = 0; it < 40; it++) begin
            if (it % 8 == 0) begin
                drain();
                blk4 = $urandom % 2;
                key  = $urandom;
            end
            im = $urandom % 2; om = $urandom % 2;
            di = $urandom % 2; dout = $urandom % 2;
            nb = $urandom % (9 - in_m);
            for (int k = 0; k < nb; k++) wr($urandom);
            settle();
            check_flags();
            nb = $urandom % (out_m + 1);
            for (int k = 0; k < nb; k++) rd("R5 random data");
            settle();
            check_flags();
        end
        drain();
        // R9: everything read -> quiet flags together
        chk("R9 final busy", busy, 1'b0);
        chk("R9 final ifem", ifem, 1'b1);
        chk("R9 final ofne", ofne, 1'b0);
        en = 1'b0;
        settle();
        chk("R9 disabled final busy", busy, 1'b0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule